// File: doc/BRIEF.md
# Inquire Cycle Snoop Responder

This block answers snoop (inquire) requests that another bus master issues against the processor's caches. When the inquire strobe is sampled high, the block takes the presented line address. It issues a one-clock read to the external instruction-cache and data-cache tag stores. It then compares the returned tags and states against the address. On the second rising edge after the strobe was sampled, it updates two active-low outputs. One reports a hit in either cache. The other reports a hit on a modified data-cache line.

Both outputs are sticky and change only when an inquiry completes. A hit on a modified line also raises a write-back request that carries the line address. The modified indication and the request stay asserted until the write-back done handshake is seen. This keeps other masters off the line until the line has been written back. A strobe that arrives while an inquiry is in flight, or while a write-back is outstanding, is held in a single-entry slot. It is launched when the block becomes free.

Top module: `snoop_resp`

## Requirements
- R1: While reset is asserted and after it is released, hit_n and hitm_n are high and wb_req and lk_en are low, until the first inquiry completes.
- R2: When the block is idle and snp_valid is sampled high on a rising edge, lk_en is high for exactly the following cycle. During that cycle lk_idx equals the low IDX_W bits of snp_line.
- R3: On the second rising edge after an idle strobe is sampled, hit_n goes low if the line hits, and goes high if it misses. A hit means ic_vld=1 with ic_tag equal to the upper TAG_W bits of the line, or dc_state not 2'b00 with dc_tag equal to those bits. The dc_state codes are 00 invalid, 01 shared, 10 exclusive and 11 modified.
- R4: hit_n changes on no edge other than the one that completes an inquiry.
- R5: When the data-cache match has dc_state 2'b11, hitm_n goes low on the completing edge. On the same edge wb_req goes high and wb_line takes the inquired line address. While hitm_n is low, hit_n is also low.
- R6: hitm_n and wb_req keep their values on every edge where wb_done is low. They return high and low respectively on the edge where wb_done is sampled high.
- R7: A strobe sampled while an inquiry is in flight, or while a write-back is outstanding, is stored. It issues no lookup until the block is free. Its lookup (lk_en) starts on the edge where the write-back done is taken, or on the edge after the earlier inquiry completes. Its result appears two edges after that.
- R8: A strobe sampled while the stored slot is already full and not being launched is discarded and never produces a lookup.
- R9: wb_done sampled high while no write-back is outstanding changes none of hit_n, hitm_n or wb_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snp_valid | input | 1 | Inquire strobe, active high |
| snp_line | input | LINE_ADDR_W | Inquired line address (tag above index) |
| lk_en | output | 1 | Tag-store read enable, one cycle per lookup |
| lk_idx | output | IDX_W | Tag-store read index |
| ic_tag | input | TAG_W | Instruction-cache tag, returned one clock after lk_en |
| ic_vld | input | 1 | Instruction-cache valid bit, returned with ic_tag |
| dc_tag | input | TAG_W | Data-cache tag, returned one clock after lk_en |
| dc_state | input | 2 | Data-cache line state, returned with dc_tag |
| wb_req | output | 1 | Write-back request for a modified hit |
| wb_line | output | LINE_ADDR_W | Line address to write back |
| wb_done | input | 1 | Write-back complete handshake |
| hit_n | output | 1 | Inquiry hit, active low, sticky |
| hitm_n | output | 1 | Hit to a modified line, active low, held until write-back done |

## Verification
The hardest situation to reach is a strobe that lands while a modified write-back is outstanding, followed by a further strobe while the slot is already full. The bench first forces a modified hit through the tag-store model. It then presents two strobes on consecutive cycles before pulsing wb_done. It checks that exactly one lookup follows, and that this lookup starts on the release edge. Consecutive strobes during an ordinary lookup exercise the second way the slot drains. A sweep over all 32 combinations of instruction-cache validity and match, data-cache state and match covers the hit decode.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_EXC = 2'b10,
    LN_MOD = 2'b11
  } line_st_e;
endpackage

// File: rtl/snoop_issue.sv
// Accepts inquire strobes, holds one waiting request, runs the two-stage lookup pipe.
module snoop_issue #(
  parameter int LINE_ADDR_W = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snp_valid,
  input  logic [LINE_ADDR_W-1:0] snp_line,
  input  logic                   wb_pend,
  input  logic                   wb_done,
  output logic                   s0_v,
  output logic [LINE_ADDR_W-1:0] s0_line,
  output logic                   s1_v,
  output logic [LINE_ADDR_W-1:0] s1_line
);
  logic                   slot_q, slot_d;
  logic [LINE_ADDR_W-1:0] slot_line_q, slot_line_d;
  logic                   s0_q, s0_d, s1_q, s1_d;
  logic [LINE_ADDR_W-1:0] s0_line_q, s0_line_d, s1_line_q, s1_line_d;
  logic                   idle_now, launch_slot, take_direct;

  always_comb begin
    idle_now    = !s0_q && !s1_q && (!wb_pend || wb_done);
    launch_slot = slot_q && idle_now;
    take_direct = snp_valid && !slot_q && idle_now;

    slot_d      = slot_q;
    slot_line_d = slot_line_q;
    if (launch_slot) begin
      slot_d      = snp_valid;
      slot_line_d = snp_valid ? snp_line : slot_line_q;
    end else if (snp_valid && !slot_q && !take_direct) begin
      slot_d      = 1'b1;
      slot_line_d = snp_line;
    end

    s0_d      = launch_slot || take_direct;
    s0_line_d = s0_line_q;
    if (launch_slot)      s0_line_d = slot_line_q;
    else if (take_direct) s0_line_d = snp_line;

    s1_d      = s0_q;
    s1_line_d = s0_q ? s0_line_q : s1_line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q      <= 1'b0;
      slot_line_q <= '0;
      s0_q        <= 1'b0;
      s0_line_q   <= '0;
      s1_q        <= 1'b0;
      s1_line_q   <= '0;
    end else begin
      slot_q      <= slot_d;
      slot_line_q <= slot_line_d;
      s0_q        <= s0_d;
      s0_line_q   <= s0_line_d;
      s1_q        <= s1_d;
      s1_line_q   <= s1_line_d;
    end
  end

  assign s0_v    = s0_q;
  assign s0_line = s0_line_q;
  assign s1_v    = s1_q;
  assign s1_line = s1_line_q;
endmodule

// File: rtl/snoop_match.sv
// Compares returned tag-store data with the inquired tag.
module snoop_match
  import snoop_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] ic_tag,
  input  logic             ic_vld,
  input  logic [TAG_W-1:0] dc_tag,
  input  logic [1:0]       dc_state,
  output logic             any_hit,
  output logic             mod_hit
);
  line_st_e st;
  logic     ic_hit, dc_hit;

  always_comb begin
    st      = line_st_e'(dc_state);
    ic_hit  = ic_vld && (ic_tag == tag);
    dc_hit  = (st != LN_INV) && (dc_tag == tag);
    any_hit = ic_hit || dc_hit;
    mod_hit = dc_hit && (st == LN_MOD);
  end
endmodule

// File: rtl/snoop_hold.sv
// Sticky response registers and write-back hold.
module snoop_hold #(
  parameter int LINE_ADDR_W = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   done,
  input  logic                   any_hit,
  input  logic                   mod_hit,
  input  logic [LINE_ADDR_W-1:0] line,
  input  logic                   wb_done,
  output logic                   hit_n,
  output logic                   hitm_n,
  output logic [LINE_ADDR_W-1:0] wb_line
);
  logic                   hit_n_q, hit_n_d, hitm_n_q, hitm_n_d;
  logic [LINE_ADDR_W-1:0] wb_line_q, wb_line_d;

  always_comb begin
    hit_n_d   = hit_n_q;
    hitm_n_d  = hitm_n_q;
    wb_line_d = wb_line_q;
    if (done) begin
      hit_n_d = !any_hit;
      if (mod_hit) begin
        hitm_n_d  = 1'b0;
        wb_line_d = line;
      end
    end else if (!hitm_n_q && wb_done) begin
      hitm_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_n_q   <= 1'b1;
      hitm_n_q  <= 1'b1;
      wb_line_q <= '0;
    end else begin
      hit_n_q   <= hit_n_d;
      hitm_n_q  <= hitm_n_d;
      wb_line_q <= wb_line_d;
    end
  end

  assign hit_n   = hit_n_q;
  assign hitm_n  = hitm_n_q;
  assign wb_line = wb_line_q;
endmodule

// File: rtl/snoop_resp.sv
module snoop_resp #(
  parameter int LINE_ADDR_W = 11,
  parameter int IDX_W       = 4,
  localparam int TAG_W      = LINE_ADDR_W - IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snp_valid,
  input  logic [LINE_ADDR_W-1:0] snp_line,
  output logic                   lk_en,
  output logic [IDX_W-1:0]       lk_idx,
  input  logic [TAG_W-1:0]       ic_tag,
  input  logic                   ic_vld,
  input  logic [TAG_W-1:0]       dc_tag,
  input  logic [1:0]             dc_state,
  output logic                   wb_req,
  output logic [LINE_ADDR_W-1:0] wb_line,
  input  logic                   wb_done,
  output logic                   hit_n,
  output logic                   hitm_n
);
  logic                   rst_meta, rst_sync_n;
  logic                   s0_v, s1_v, any_hit, mod_hit;
  logic [LINE_ADDR_W-1:0] s0_line, s1_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  snoop_issue #(.LINE_ADDR_W(LINE_ADDR_W)) u_issue (
    .clk(clk), .rst_n(rst_sync_n), .snp_valid(snp_valid), .snp_line(snp_line),
    .wb_pend(!hitm_n), .wb_done(wb_done),
    .s0_v(s0_v), .s0_line(s0_line), .s1_v(s1_v), .s1_line(s1_line)
  );

  snoop_match #(.TAG_W(TAG_W)) u_match (
    .tag(s1_line[LINE_ADDR_W-1:IDX_W]), .ic_tag(ic_tag), .ic_vld(ic_vld),
    .dc_tag(dc_tag), .dc_state(dc_state), .any_hit(any_hit), .mod_hit(mod_hit)
  );

  snoop_hold #(.LINE_ADDR_W(LINE_ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .done(s1_v), .any_hit(any_hit),
    .mod_hit(mod_hit), .line(s1_line), .wb_done(wb_done),
    .hit_n(hit_n), .hitm_n(hitm_n), .wb_line(wb_line)
  );

  assign lk_en  = s0_v;
  assign lk_idx = s0_line[IDX_W-1:0];
  assign wb_req = !hitm_n;
endmodule

// File: rtl/snoop_resp_chk.sv
module snoop_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic s1_v,
  input logic lk_en,
  input logic wb_done,
  input logic hit_n,
  input logic hitm_n
);
  // R4
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_v |=> $stable(hit_n));
  // R5
  hitm_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |-> !hit_n);
  // R6
  hitm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitm_n && !wb_done) |=> !hitm_n);
  // R6
  hitm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitm_n && wb_done) |=> hitm_n);
  // R9
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hitm_n && !s1_v) |=> hitm_n);
  // R2
  single_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> !lk_en);
endmodule

bind snoop_resp snoop_resp_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .s1_v(s1_v), .lk_en(lk_en),
  .wb_done(wb_done), .hit_n(hit_n), .hitm_n(hitm_n)
);

// File: tb/snoop_resp_tb.sv
module snoop_resp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LA = 11;
  localparam int IW = 4;
  localparam int TW = LA - IW;

  logic clk = 1'b0, rst_n = 1'b0, snp_valid = 1'b0, wb_done = 1'b0;
  logic [LA-1:0] snp_line = '0;
  logic lk_en, ic_vld, wb_req, hit_n, hitm_n;
  logic [IW-1:0] lk_idx;
  logic [TW-1:0] ic_tag, dc_tag;
  logic [1:0] dc_state;
  logic [LA-1:0] wb_line;

  logic [TW-1:0] ic_mem [16];
  logic          icv_mem [16];
  logic [TW-1:0] dc_mem [16];
  logic [1:0]    dst_mem [16];
  int n_chk = 0, n_err = 0, lk_cnt = 0;
  logic cur_hit_n = 1'b1;

  snoop_resp u_dut (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_line(snp_line),
    .lk_en(lk_en), .lk_idx(lk_idx), .ic_tag(ic_tag), .ic_vld(ic_vld),
    .dc_tag(dc_tag), .dc_state(dc_state), .wb_req(wb_req), .wb_line(wb_line),
    .wb_done(wb_done), .hit_n(hit_n), .hitm_n(hitm_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tag-store model: one-clock registered read
  always @(posedge clk) begin
    if (lk_en) begin
      ic_tag   <= ic_mem[lk_idx];
      ic_vld   <= icv_mem[lk_idx];
      dc_tag   <= dc_mem[lk_idx];
      dc_state <= dst_mem[lk_idx];
      lk_cnt   <= lk_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_line(input logic [IW-1:0] idx, input logic [TW-1:0] tag,
                          input logic icv, input logic icm, input logic [1:0] st, input logic dcm);
    icv_mem[idx] = icv;
    ic_mem[idx]  = icm ? tag : tag ^ 7'd1;
    dst_mem[idx] = st;
    dc_mem[idx]  = dcm ? tag : tag ^ 7'd2;
  endtask

  task automatic inquire(input logic [LA-1:0] line, input logic ehit, input logic emod);
    @(negedge clk); snp_valid = 1'b1; snp_line = line;
    @(negedge clk); snp_valid = 1'b0;
    chk("R2 lk_en", lk_en, 1); chk("R2 lk_idx", lk_idx, line[IW-1:0]);
    @(negedge clk);
    chk("R4 hit_n before completion", hit_n, cur_hit_n);
    @(negedge clk);
    chk("R3 hit_n", hit_n, !ehit); chk("R5 hitm_n", hitm_n, !emod);
    cur_hit_n = !ehit;
    if (emod) begin
      chk("R5 wb_req", wb_req, 1); chk("R5 wb_line", wb_line, line);
    end
  endtask

  task automatic finish_wb();
    cyc(2);
    chk("R6 hitm_n held", hitm_n, 0); chk("R6 wb_req held", wb_req, 1);
    wb_done = 1'b1;
    @(negedge clk); wb_done = 1'b0;
    chk("R6 hitm_n released", hitm_n, 1); chk("R6 wb_req released", wb_req, 0);
    chk("R4 hit_n kept over release", hit_n, cur_hit_n);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [LA-1:0] base;
    for (int i = 0; i < 16; i++) set_line(4'(i), '0, 0, 0, 2'b00, 0);
    cyc(4);
    chk("R1 hit_n in reset", hit_n, 1); chk("R1 hitm_n in reset", hitm_n, 1);
    chk("R1 wb_req in reset", wb_req, 0); chk("R1 lk_en in reset", lk_en, 0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 hit_n after reset", hit_n, 1); chk("R1 lk_en after reset", lk_en, 0);

    // R9 stray write-back done
    wb_done = 1'b1; @(negedge clk); wb_done = 1'b0; @(negedge clk);
    chk("R9 hit_n", hit_n, 1); chk("R9 hitm_n", hitm_n, 1); chk("R9 wb_req", wb_req, 0);

    // R3 R5 sweep over all lookup combinations
    for (int c = 0; c < 32; c++) begin
      logic icv, icm, dcm, eh, em;
      logic [1:0] st;
      logic [TW-1:0] tg;
      icv = c[0]; icm = c[1]; st = 2'(c >> 2); dcm = c[4];
      tg = 7'(c * 3 + 1);
      set_line(4'(c), tg, icv, icm, st, dcm);
      eh = (icv && icm) || ((st != 2'b00) && dcm);
      em = (st == 2'b11) && dcm;
      inquire({tg, 4'(c)}, eh, em);
      if (em) finish_wb();
      cyc(1);
    end

    // R7 R8: strobes while write-back outstanding
    set_line(4'd2, 7'h11, 0, 0, 2'b11, 1);
    set_line(4'd5, 7'h22, 0, 0, 2'b00, 0);
    set_line(4'd7, 7'h33, 1, 1, 2'b00, 0);
    inquire({7'h11, 4'd2}, 1, 1);
    @(negedge clk); snp_valid = 1'b1; snp_line = {7'h22, 4'd5};
    @(negedge clk); snp_line = {7'h33, 4'd7};
    @(negedge clk); snp_valid = 1'b0;
    base = LA'(lk_cnt);
    cyc(3);
    chk("R7 no lookup during write-back", lk_cnt, base); chk("R7 hitm_n still low", hitm_n, 0);
    wb_done = 1'b1; @(negedge clk); wb_done = 1'b0;
    chk("R7 queued lookup at release", lk_en, 1); chk("R7 queued lk_idx", lk_idx, 5);
    chk("R6 hitm_n released", hitm_n, 1);
    cyc(2);
    chk("R7 queued result hit_n", hit_n, 1);
    cyc(5);
    chk("R8 dropped strobe made no lookup", lk_cnt, 32'(base) + 1);
    chk("R8 hit_n unchanged", hit_n, 1);

    // R7: back-to-back strobes during a lookup
    set_line(4'd9, 7'h44, 1, 1, 2'b00, 0);
    set_line(4'd10, 7'h55, 0, 0, 2'b01, 0);
    @(negedge clk); snp_valid = 1'b1; snp_line = {7'h44, 4'd9};
    @(negedge clk); snp_line = {7'h55, 4'd10};
    @(negedge clk); snp_valid = 1'b0;
    @(negedge clk); chk("R3 first of pair hits", hit_n, 0);
    @(negedge clk); chk("R7 second launches", lk_en, 1); chk("R7 second lk_idx", lk_idx, 10);
    cyc(1); chk("R4 hit_n kept before second result", hit_n, 0);
    cyc(1); chk("R7 second result misses", hit_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule